// File: doc/BRIEF.md
# Option ROM Byte-Lane Read Adapter

This block answers 32-bit reads aimed at a region that holds up to four option-board ROM slots. Each slot is byte-wide storage. The byte at index zero of a slot says how many ROM chips the board carries: one, two or four. The adapter uses that count to pick the address stride and the number of bytes it packs into the returned longword. Bytes are packed little-endian, and the upper lanes that the board does not drive read as ones. A slot that is absent, or that holds a count other than 1, 2 or 4, reads as all ones.

The slot contents are built in at elaboration. A per-slot presence mask and a per-slot chip count are parameters, and the remaining bytes follow a fixed fill rule, so the storage maps onto inferred read-only memory. Writes into the region are accepted and have no effect. Every read returns registered data one clock after the read strobe.

Top module: `optrom_reader`

## Requirements
- R1: Address bits [19:18] choose the slot (0 to 3). Bits [17:0] are the byte offset inside the slot.
- R2: Byte 0 of slot s holds that slot's chip count, taken from bits [8s+7:8s] of SLOT_CHIPS. Byte i (i ≥ 1) of slot s holds the low 8 bits of ((37·i + 101·s + 13) XOR (i >> 4)).
- R3: With a count of 1, the returned word is the byte at index (offset >> 2) in bits [7:0], with bits [31:8] all ones.
- R4: With a count of 2, the bytes at index b = (offset >> 1) and b+1 fill bits [7:0] and [15:8] respectively, and bits [31:16] are all ones.
- R5: With a count of 4, the bytes at index offset, offset+1, offset+2 and offset+3 fill bits [7:0], [15:8], [23:16] and [31:24]. The offset may be unaligned.
- R6: Every byte index, including the +1/+2/+3 neighbours, wraps modulo SLOT_BYTES (default 256).
- R7: A slot whose bit in SLOT_PRESENT is 0 returns 0xFFFFFFFF.
- R8: A present slot whose count byte is not 1, 2 or 4 returns 0xFFFFFFFF.
- R9: A write strobe changes neither rd_valid nor rd_data, and it does not change what any later read returns.
- R10: rd_valid is high in exactly the cycle after a read strobe, and rd_data holds the result in that cycle. rd_data keeps its value until the next read.
- R11: While reset is held and after it is released, rd_valid is 0 and rd_data is 0xFFFFFFFF until the first read.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (discarded) |
| addr | input | 20 | Byte offset from the region base: slot in [19:18], offset in [17:0] |
| wr_data | input | 32 | Write data (discarded) |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | 32 | Assembled read word |

## Verification
Each read sends four lane addresses into interleaved banks, and a registered rotation plus mode rebuilds the word. A wrong lane address or rotation shows up as misplaced or swapped bytes in the very next valid word. Unaligned and wrap-around offsets are where this happens first. A stale or wrong mode register shows at the same cycle, as ones missing from the padded lanes or as ones appearing where data belongs. Comparing every cycle against a behavioural model, for two parameter sets, also catches data that changes between reads.

// File: rtl/optrom_pkg.sv
package optrom_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_BYTE = 2'd1,
    MODE_HALF = 2'd2,
    MODE_WORD = 2'd3
  } optrom_mode_e;

  // Built-in slot contents: index 0 carries the chip count, the rest a fill pattern.
  function automatic logic [7:0] optrom_fill(int slot, int idx, logic [7:0] count);
    int v;
    if (idx == 0) return count;
    v = (idx * 37 + slot * 101 + 13) ^ (idx >> 4);
    return v[7:0];
  endfunction

  function automatic optrom_mode_e optrom_decode(logic present, logic [7:0] count);
    if (!present) return MODE_NONE;
    case (count)
      8'd1:    return MODE_BYTE;
      8'd2:    return MODE_HALF;
      8'd4:    return MODE_WORD;
      default: return MODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/optrom_lane_rom.sv
module optrom_lane_rom
  import optrom_pkg::*;
#(
  parameter int         SLOT  = 0,
  parameter int         LANE  = 0,
  parameter int         DEPTH = 64,
  parameter logic [7:0] COUNT = 8'd1,
  localparam int        AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // Bank LANE holds every byte whose index is congruent to LANE modulo LANES.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = optrom_fill(SLOT, i * LANES + LANE, COUNT);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[raddr];
  end

endmodule

// File: rtl/optrom_addr_map.sv
module optrom_addr_map
  import optrom_pkg::*;
#(
  parameter int  OFF_W = 18,
  parameter int  IDX_W = 8,
  localparam int LA_W  = IDX_W - 2
) (
  input  optrom_mode_e                mode,
  input  logic [OFF_W-1:0]            off,
  output logic [LANES-1:0][LA_W-1:0]  lane_addr,
  output logic [1:0]                  rot
);

  logic [IDX_W-1:0] base;

  // Stride follows the chip count; truncation to IDX_W is the capacity wrap.
  always_comb begin
    case (mode)
      MODE_BYTE: base = IDX_W'(off >> 2);
      MODE_HALF: base = IDX_W'(off >> 1);
      default:   base = IDX_W'(off);
    endcase
  end

  assign rot = base[1:0];

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0] step;
    assign step         = 2'(b) - base[1:0];
    assign lane_addr[b] = LA_W'((base + IDX_W'(step)) >> 2);
  end

endmodule

// File: rtl/optrom_lane_pack.sv
module optrom_lane_pack
  import optrom_pkg::*;
(
  input  optrom_mode_e               mode,
  input  logic [1:0]                 rot,
  input  logic [LANES-1:0][7:0]      lanes,
  output logic [WORD_W-1:0]          word
);

  logic [LANES-1:0][7:0] ordered;

  for (genvar k = 0; k < LANES; k++) begin : g_order
    assign ordered[k] = lanes[rot + 2'(k)];
  end

  always_comb begin
    case (mode)
      MODE_BYTE: word = {24'hFF_FFFF, ordered[0]};
      MODE_HALF: word = {16'hFFFF, ordered[1], ordered[0]};
      MODE_WORD: word = ordered;
      default:   word = '1;
    endcase
  end

endmodule

// File: rtl/optrom_reader.sv
module optrom_reader
  import optrom_pkg::*;
#(
  parameter int          OFF_W        = 18,
  parameter int          SLOT_BYTES   = 256,
  parameter logic [3:0]  SLOT_PRESENT = 4'b0111,
  parameter logic [31:0] SLOT_CHIPS   = 32'h04_04_02_01,
  localparam int         NUM_SLOTS    = 4,
  localparam int         SEL_W        = 2,
  localparam int         ADDR_W       = OFF_W + SEL_W,
  localparam int         IDX_W        = $clog2(SLOT_BYTES),
  localparam int         LA_W         = IDX_W - 2,
  localparam int         LANE_DEPTH   = SLOT_BYTES / LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);

  logic [SEL_W-1:0]                         sel;
  logic [OFF_W-1:0]                         off;
  optrom_mode_e                             slot_mode [NUM_SLOTS];
  optrom_mode_e                             mode_now;
  logic [LANES-1:0][LA_W-1:0]               lane_addr;
  logic [1:0]                               rot_now;
  logic [NUM_SLOTS-1:0][LANES-1:0][7:0]     lane_q;

  logic [SEL_W-1:0]  sel_q;
  optrom_mode_e      mode_q;
  logic [1:0]        rot_q;

  logic unused_wr;
  assign unused_wr = wr_en | (|wr_data);

  assign sel = addr[ADDR_W-1 -: SEL_W];
  assign off = addr[OFF_W-1:0];

  // Per-slot mode, shadowing the count byte stored at index 0.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [7:0] CNT = SLOT_CHIPS[s*8 +: 8];
    assign slot_mode[s] = optrom_decode(SLOT_PRESENT[s], CNT);

    for (genvar l = 0; l < LANES; l++) begin : g_bank
      optrom_lane_rom #(
        .SLOT  (s),
        .LANE  (l),
        .DEPTH (LANE_DEPTH),
        .COUNT (CNT)
      ) u_bank (
        .clk   (clk),
        .rd_en (rd_en),
        .raddr (lane_addr[l]),
        .rdata (lane_q[s][l])
      );
    end
  end

  assign mode_now = slot_mode[sel];

  optrom_addr_map #(
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_map (
    .mode      (mode_now),
    .off       (off),
    .lane_addr (lane_addr),
    .rot       (rot_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= '0;
      mode_q   <= MODE_NONE;
      rot_q    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_q  <= sel;
        mode_q <= mode_now;
        rot_q  <= rot_now;
      end
    end
  end

  optrom_lane_pack u_pack (
    .mode  (mode_q),
    .rot   (rot_q),
    .lanes (lane_q[sel_q]),
    .word  (rd_data)
  );

endmodule

// File: rtl/optrom_reader_chk.sv
module optrom_reader_chk #(
  parameter int          OFF_W        = 18,
  parameter logic [3:0]  SLOT_PRESENT = 4'b0111,
  parameter logic [31:0] SLOT_CHIPS   = 32'h04_04_02_01,
  localparam int         ADDR_W       = OFF_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data
);

  logic [1:0] sel;
  logic [7:0] cnt_now;
  logic       present_now;
  logic       count_ok;
  logic       unused_off;

  assign sel         = addr[ADDR_W-1 -: 2];
  assign cnt_now     = SLOT_CHIPS[{sel, 3'b000} +: 8];
  assign present_now = SLOT_PRESENT[sel];
  assign count_ok    = (cnt_now == 8'd1) || (cnt_now == 8'd2) || (cnt_now == 8'd4);
  assign unused_off  = ^addr;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R10

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R10

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10

  AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !present_now) |=> (rd_data == 32'hFFFF_FFFF)); // R7

  AST_BADCOUNT_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && present_now && !count_ok) |=> (rd_data == 32'hFFFF_FFFF)); // R8

  AST_BYTE_PAD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && present_now && cnt_now == 8'd1) |=> (rd_data[31:8] == 24'hFF_FFFF)); // R3

  AST_HALF_PAD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && present_now && cnt_now == 8'd2) |=> (rd_data[31:16] == 16'hFFFF)); // R4

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (!rd_valid && $stable(rd_data))); // R9

endmodule

bind optrom_reader optrom_reader_chk #(
  .OFF_W        (OFF_W),
  .SLOT_PRESENT (SLOT_PRESENT),
  .SLOT_CHIPS   (SLOT_CHIPS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/optrom_reader_test.sv
`timescale 1ns/1ps
module optrom_reader_test;

  localparam logic [3:0]  PRES_A  = 4'b0111;
  localparam logic [31:0] CHIPS_A = 32'h04_04_02_01;
  localparam logic [3:0]  PRES_B  = 4'b1111;
  localparam logic [31:0] CHIPS_B = 32'h03_04_02_01;
  localparam int          CAP     = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic        rv [2];
  logic [31:0] rdat [2];

  int checks = 0;
  int failures = 0;
  bit         exp_valid [2];
  logic [31:0] exp_data [2];
  string      exp_tag [2];

  always #4 clk = ~clk;

  optrom_reader #(.SLOT_PRESENT(PRES_A), .SLOT_CHIPS(CHIPS_A)) uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_valid(rv[0]), .rd_data(rdat[0]));

  optrom_reader #(.SLOT_PRESENT(PRES_B), .SLOT_CHIPS(CHIPS_B)) uut_alt (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_valid(rv[1]), .rd_data(rdat[1]));

  function automatic logic [7:0] ref_byte(int s, int idx, int cnt);
    if (idx == 0) return 8'(cnt);
    return 8'((idx * 37 + s * 101 + 13) ^ (idx >> 4));
  endfunction

  function automatic logic [31:0] ref_read(int inst, logic [19:0] a, string tag_in, output string tag);
    logic [3:0]  pres  = (inst == 0) ? PRES_A : PRES_B;
    logic [31:0] chips = (inst == 0) ? CHIPS_A : CHIPS_B;
    int s   = int'(a[19:18]);
    int off = int'(a[17:0]);
    int cnt = int'(chips[s*8 +: 8]);
    int b;
    logic [31:0] w;
    if (!pres[s]) begin tag = "R7"; return 32'hFFFF_FFFF; end
    if (cnt != 1 && cnt != 2 && cnt != 4) begin tag = "R8"; return 32'hFFFF_FFFF; end
    case (cnt)
      1: begin b = (off >> 2) % CAP; w = {24'hFF_FFFF, ref_byte(s, b, cnt)}; tag = "R3"; end
      2: begin
        b = (off >> 1) % CAP;
        w = {16'hFFFF, ref_byte(s, (b + 1) % CAP, cnt), ref_byte(s, b, cnt)};
        tag = "R4";
      end
      default: begin
        b = off % CAP;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = ref_byte(s, (b + k) % CAP, cnt);
        tag = "R5";
      end
    endcase
    if (tag_in != "") tag = tag_in;
    return w;
  endfunction

  task automatic compare(int i);
    checks++;
    if (rv[i] !== exp_valid[i]) begin
      failures++;
      $display("FAIL R10 inst%0d rd_valid actual=%0b expected=%0b", i, rv[i], exp_valid[i]);
    end
    checks++;
    if (rdat[i] !== exp_data[i]) begin
      failures++;
      $display("FAIL %s inst%0d rd_data actual=%08h expected=%08h", exp_tag[i], i, rdat[i], exp_data[i]);
    end
  endtask

  task automatic step(bit rd, bit wr, logic [19:0] a, logic [31:0] wd, string tag);
    string t;
    @(negedge clk);
    compare(0);
    compare(1);
    rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
    for (int i = 0; i < 2; i++) begin
      if (rd) begin
        exp_valid[i] = 1'b1;
        exp_data[i]  = ref_read(i, a, tag, t);
        exp_tag[i]   = t;
      end else begin
        exp_valid[i] = 1'b0;
        exp_tag[i]   = wr ? "R9" : "R10";
      end
    end
  endtask

  function automatic logic [19:0] mk(int s, int off);
    return {2'(s), 18'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < 2; i++) begin
      exp_valid[i] = 1'b0; exp_data[i] = 32'hFFFF_FFFF; exp_tag[i] = "R11";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(0); compare(1);          // R11 during reset
    rst = 1'b0;
    step(0, 0, '0, '0, "");          // R11 after release
    // R2: count byte at index 0
    step(1, 0, mk(0, 0), '0, "R2");
    step(1, 0, mk(2, 0), '0, "R2");
    step(1, 0, mk(1, 0), '0, "R2");
    // R3, R4, R5 basic assembly
    step(1, 0, mk(0, 'h14), '0, "R3");
    step(1, 0, mk(1, 'h0A), '0, "R4");
    step(1, 0, mk(2, 'h17), '0, "R5");
    step(1, 0, mk(2, 'h40), '0, "R5");
    // R6 wrap cases
    step(1, 0, mk(2, 'hFE), '0, "R6");
    step(1, 0, mk(2, 'hFF), '0, "R6");
    step(1, 0, mk(1, 'h1FF), '0, "R6");
    step(1, 0, mk(0, 'h3FFFC), '0, "R6");
    step(1, 0, mk(2, 'h30105), '0, "R6");
    // R7 / R8: slot 3 absent in uut, bad count in uut_alt
    step(1, 0, mk(3, 'h10), '0, "");
    step(0, 0, '0, '0, "");
    // R1: same offset, each slot
    for (int s = 0; s < 4; s++) step(1, 0, mk(s, 'h21), '0, "R1");
    // R9: writes then reads at the same spot
    step(1, 0, mk(2, 'h17), '0, "R9");
    step(0, 1, mk(2, 'h17), 32'h0, "");
    step(0, 1, mk(0, 'h14), 32'h1234_5678, "");
    step(1, 1, mk(2, 'h17), 32'hDEAD_BEEF, "R9");
    step(1, 0, mk(0, 'h14), '0, "R9");
    // R10: idle cycles hold the data
    step(0, 0, '0, '0, "");
    step(0, 0, mk(1, 'h33), '0, "");
    // mixed pseudo-random reads with occasional idles
    seed = 32'h1357;
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[3:0] != 4'd0, seed[5], 20'(seed >>> 8), 32'(seed), "");
    end
    step(0, 0, '0, '0, "");
    @(negedge clk);
    compare(0); compare(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule